// File: doc/BRIEF.md
# Board Control and Memory Error Register File

This block holds the small set of control and status registers that sit on a minicomputer CPU board. Four 32-bit registers are reached by longword offset on a simple word-addressed read/write port. The first register holds the boot and diagnostic settings. The second collects memory-system error flags. The third holds the address captured on a CPU-side memory error, and the fourth holds the address captured on a DMA-side memory error.

Each register combines several kinds of field. Some are fixed at reset and read-only, such as the strap codes, power-good and break enable. Some are plain writable bits. Others are sticky error flags that hardware sets and software clears by writing ones.

The memory subsystem drives the status side of the block. It supplies single-cycle error event pulses, a machine-check pulse for bad memory references, a two-bit memory code strap, and two captured 15-bit error addresses. The block drives the four-bit LED display nibble and the break enable level back out to the board. Read data is registered and appears one cycle after the read request.

Top module: `board_ctl_regfile`

## Requirements
- R1: In a cycle with `rst` high, the registers load their reset values. The boot/diagnostic register reads 0x0000C30F when `full_diag` is 0 and 0x0000C00F when it is 1. In both cases power-good (bit 15) is 1, break enable (bit 14) is 1, the CPU code (bits 12:11) is 0, the display (bits 3:0) is 0xF, and the boot code (bits 9:8) is 0 in full-diagnostic mode and 3 otherwise. The memory error register and both error address registers read 0. `led_out` is 0xF and `brk_en` is 1.
- R2: Registers are selected by `bus_addr`: 0 is boot/diagnostic, 1 is memory error, 2 is CPU error address and 3 is DMA error address. A read at any other offset returns 0.
- R3: A write to offset 0 changes only bits 3:0, which drive `led_out` from the next cycle. All other bits of that register keep their values, so `brk_en` stays 1.
- R4: A write to offset 1 loads bits 1:0 (parity enable, write wrong parity) from `bus_wdata[1:0]`. Bit 2 and bits 31:10 of that register always read 0.
- R5: For bits 7:3 of the memory error register (bit 3 lost error, bit 4 DMA parity, bit 5 CPU bus parity, bit 6 CPU memory parity, bit 7 non-existent memory), a write to offset 1 clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R6: A one-cycle pulse on `ev_lost`, `ev_dma_par`, `ev_cpu_bus_par` or `ev_cpu_mem_par` sets bit 3, 4, 5 or 6 respectively from the next cycle. If a pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R7: A pulse on `ev_mref_mchk` sets bit 7 unless bit 5 or bit 6 was already set before that cycle. A parity pulse in the same cycle as the machine-check pulse does not block the setting of bit 7.
- R8: Bits 9:8 of the memory error register reflect `mem_code`, with a delay of one register stage.
- R9: A pulse on `cpu_ea_cap` or `dma_ea_cap` loads `cpu_ea_in` or `dma_ea_in` into the CPU or DMA error address register in the cycle after the strobe. A read returns the address in bits 14:0 and 0 in bits 31:15.
- R10: Writes to offsets 2 and 3 leave the error address registers unchanged.
- R11: `bus_rdata` is 0 after reset. It is updated only at the clock edge that takes a read request (`bus_sel` high, `bus_we` low), with the value the register held before that edge. In all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_diag | input | 1 | Full-diagnostic mode; selects the boot code loaded at reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Longword offset from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mem_code | input | 2 | Memory code strap |
| ev_lost | input | 1 | Lost-error event pulse |
| ev_dma_par | input | 1 | DMA bus parity error pulse |
| ev_cpu_bus_par | input | 1 | CPU bus parity error pulse |
| ev_cpu_mem_par | input | 1 | CPU memory parity error pulse |
| ev_mref_mchk | input | 1 | Memory-reference machine check pulse |
| cpu_ea_cap | input | 1 | Capture strobe for the CPU error address |
| cpu_ea_in | input | 15 | CPU error address to capture |
| dma_ea_cap | input | 1 | Capture strobe for the DMA error address |
| dma_ea_in | input | 15 | DMA error address to capture |
| led_out | output | 4 | LED display nibble |
| brk_en | output | 1 | Halt/break enable |

## Verification
The properties assume the following about the inputs:
- Event and capture inputs are single-cycle pulses that are sampled only at rising edges.
- Every bus access lasts exactly one cycle.
- `rst` is held high from time zero for at least one edge.

The bench drives every input at the falling edge and returns each pulse to zero by the next falling edge, so no event stretches across two edges. It also keeps `mem_code` stable for at least two cycles before any read that depends on it.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 4;

  // Register offsets (longword index)
  localparam int OFS_BDIAG  = 0;
  localparam int OFS_MEMERR = 1;
  localparam int OFS_CPUEA  = 2;
  localparam int OFS_DMAEA  = 3;

  // Boot/diagnostic field positions
  localparam int BD_DISP_LSB = 0;
  localparam int BD_DISP_W   = 4;
  localparam int BD_BOOT_LSB = 8;
  localparam int BD_CPU_LSB  = 11;
  localparam int BD_BRK_BIT  = 14;
  localparam int BD_POK_BIT  = 15;

  typedef enum logic [1:0] {
    BOOT_NORMAL   = 2'd0,
    BOOT_LANGINQ  = 2'd1,
    BOOT_TESTLOOP = 2'd2,
    BOOT_SKIPMEM  = 2'd3
  } boot_code_e;

  typedef enum logic [1:0] {
    CPU_ARBITER = 2'd0,
    CPU_AUX1    = 2'd1,
    CPU_AUX2    = 2'd2,
    CPU_AUX3    = 2'd3
  } cpu_code_e;

  // Memory error field positions
  localparam int ME_PE_BIT    = 0;
  localparam int ME_WWP_BIT   = 1;
  localparam int ME_STK_LSB   = 3;
  localparam int ME_STK_W     = 5;
  localparam int ME_MCODE_LSB = 8;
  localparam int ME_MCODE_W   = 2;

  // Sticky flag indices within the sticky vector (bit ME_STK_LSB + index)
  localparam int STK_LOST    = 0;
  localparam int STK_DMAPAR  = 1;
  localparam int STK_CPUBUS  = 2;
  localparam int STK_CPUMEM  = 3;
  localparam int STK_NXM     = 4;

  localparam int EA_W = 15;

endpackage

// File: rtl/bctl_bdiag.sv
module bctl_bdiag
  import board_ctl_pkg::*;
#(
  parameter int DISP_W = BD_DISP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_diag,
  input  logic              wr_en,
  input  logic [DISP_W-1:0] wr_disp,
  output logic [DATA_W-1:0] word,
  output logic [DISP_W-1:0] disp,
  output logic              brk
);

  boot_code_e boot_q;
  cpu_code_e  cpu_q;
  logic       pok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp   <= '1;
      boot_q <= full_diag ? BOOT_NORMAL : BOOT_SKIPMEM;
      cpu_q  <= CPU_ARBITER;
      brk    <= 1'b1;
      pok_q  <= 1'b1;
    end else if (wr_en) begin
      disp <= wr_disp;
    end
  end

  always_comb begin
    word = '0;
    word[BD_DISP_LSB +: DISP_W] = disp;
    word[BD_BOOT_LSB +: 2]      = boot_q;
    word[BD_CPU_LSB +: 2]       = cpu_q;
    word[BD_BRK_BIT]            = brk;
    word[BD_POK_BIT]            = pok_q;
  end

endmodule

// File: rtl/bctl_memerr.sv
module bctl_memerr
  import board_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_data,
  input  logic                  ev_lost,
  input  logic                  ev_dma_par,
  input  logic                  ev_cpu_bus_par,
  input  logic                  ev_cpu_mem_par,
  input  logic                  ev_mref_mchk,
  input  logic [ME_MCODE_W-1:0] mem_code,
  output logic [DATA_W-1:0]     word
);

  logic [1:0]            ctl_q;
  logic [ME_STK_W-1:0]   stk_q;
  logic [ME_STK_W-1:0]   stk_set;
  logic [ME_STK_W-1:0]   stk_clr;
  logic [ME_STK_W-1:0]   stk_d;
  logic [ME_MCODE_W-1:0] mcode_q;
  logic                  nxm_allowed;

  // NXM may only be flagged when no CPU-side parity flag is already pending
  assign nxm_allowed = !stk_q[STK_CPUBUS] && !stk_q[STK_CPUMEM];

  always_comb begin
    stk_set              = '0;
    stk_set[STK_LOST]    = ev_lost;
    stk_set[STK_DMAPAR]  = ev_dma_par;
    stk_set[STK_CPUBUS]  = ev_cpu_bus_par;
    stk_set[STK_CPUMEM]  = ev_cpu_mem_par;
    stk_set[STK_NXM]     = ev_mref_mchk && nxm_allowed;
    stk_clr              = wr_en ? wr_data[ME_STK_LSB +: ME_STK_W] : '0;
    // set has priority over a same-cycle clear
    stk_d                = (stk_q & ~stk_clr) | stk_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      stk_q   <= '0;
      mcode_q <= '0;
    end else begin
      stk_q   <= stk_d;
      mcode_q <= mem_code;
      if (wr_en) ctl_q <= wr_data[1:0];
    end
  end

  always_comb begin
    word                                = '0;
    word[ME_PE_BIT]                     = ctl_q[0];
    word[ME_WWP_BIT]                    = ctl_q[1];
    word[ME_STK_LSB +: ME_STK_W]        = stk_q;
    word[ME_MCODE_LSB +: ME_MCODE_W]    = mcode_q;
  end

endmodule

// File: rtl/bctl_eaddr.sv
module bctl_eaddr
  import board_ctl_pkg::*;
#(
  parameter int AW = EA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [AW-1:0]     din,
  output logic [DATA_W-1:0] word
);

  localparam int PAD_W = DATA_W - AW;

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (cap) addr_q <= din;
  end

  assign word = {{PAD_W{1'b0}}, addr_q};

endmodule

// File: rtl/board_ctl_regfile.sv
module board_ctl_regfile
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_diag,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        mem_code,
  input  logic              ev_lost,
  input  logic              ev_dma_par,
  input  logic              ev_cpu_bus_par,
  input  logic              ev_cpu_mem_par,
  input  logic              ev_mref_mchk,
  input  logic              cpu_ea_cap,
  input  logic [14:0]       cpu_ea_in,
  input  logic              dma_ea_cap,
  input  logic [14:0]       dma_ea_in,
  output logic [3:0]        led_out,
  output logic              brk_en
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0] wr_hit;
  logic [DATA_W-1:0]   reg_word [NUM_REGS];
  logic                rd_req;
  logic                in_range;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   memerr_word;
  logic [DATA_W-1:0]   cpu_ea_word;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata[31:8];

  assign in_range = (bus_addr < ADDR_W'(NUM_REGS));
  assign rd_req   = bus_sel && !bus_we;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_dec
      assign wr_hit[gi] = bus_sel && bus_we && (bus_addr == ADDR_W'(gi));
    end
  endgenerate

  bctl_bdiag #(.DISP_W(BD_DISP_W)) u_bdiag (
    .clk       (clk),
    .rst       (rst),
    .full_diag (full_diag),
    .wr_en     (wr_hit[OFS_BDIAG]),
    .wr_disp   (bus_wdata[BD_DISP_W-1:0]),
    .word      (reg_word[OFS_BDIAG]),
    .disp      (led_out),
    .brk       (brk_en)
  );

  bctl_memerr u_memerr (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_hit[OFS_MEMERR]),
    .wr_data        (bus_wdata[7:0]),
    .ev_lost        (ev_lost),
    .ev_dma_par     (ev_dma_par),
    .ev_cpu_bus_par (ev_cpu_bus_par),
    .ev_cpu_mem_par (ev_cpu_mem_par),
    .ev_mref_mchk   (ev_mref_mchk),
    .mem_code       (mem_code),
    .word           (memerr_word)
  );
  assign reg_word[OFS_MEMERR] = memerr_word;

  // Two identical error-address capture registers; bus writes never reach them
  generate
    for (gi = 0; gi < 2; gi++) begin : g_ea
      logic          cap_s;
      logic [EA_W-1:0] din_s;
      logic [DATA_W-1:0] word_s;
      if (gi == 0) begin : g_cpu
        assign cap_s = cpu_ea_cap;
        assign din_s = cpu_ea_in;
      end else begin : g_dma
        assign cap_s = dma_ea_cap;
        assign din_s = dma_ea_in;
      end
      bctl_eaddr #(.AW(EA_W)) u_ea (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap_s),
        .din  (din_s),
        .word (word_s)
      );
      assign reg_word[OFS_CPUEA + gi] = word_s;
    end
  endgenerate
  assign cpu_ea_word = reg_word[OFS_CPUEA];

  always_comb begin
    rd_mux = '0;
    if (in_range) rd_mux = reg_word[bus_addr[SEL_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/board_ctl_regfile_chk.sv
module board_ctl_regfile_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [3:0]        led_out,
  input logic              brk_en,
  input logic              ev_cpu_mem_par,
  input logic              ev_mref_mchk,
  input logic              cpu_ea_cap,
  input logic [14:0]       cpu_ea_in,
  input logic [31:0]       cpu_ea_word,
  input logic [31:0]       memerr_word
);

  assert_led_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == '0) |=> (led_out == $past(bus_wdata[3:0]) && brk_en));

  assert_memerr_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == ADDR_W'(1)) |=> (bus_rdata[31:10] == '0 && !bus_rdata[2]));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    ev_cpu_mem_par |=> memerr_word[6]);

  assert_nxm_set_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_mref_mchk && !memerr_word[5] && !memerr_word[6]) |=> memerr_word[7]);

  assert_ea_capture_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ea_cap |=> (cpu_ea_word[14:0] == $past(cpu_ea_in)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

endmodule

bind board_ctl_regfile board_ctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_sel        (bus_sel),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .led_out        (led_out),
  .brk_en         (brk_en),
  .ev_cpu_mem_par (ev_cpu_mem_par),
  .ev_mref_mchk   (ev_mref_mchk),
  .cpu_ea_cap     (cpu_ea_cap),
  .cpu_ea_in      (cpu_ea_in),
  .cpu_ea_word    (cpu_ea_word),
  .memerr_word    (memerr_word)
);

// File: tb/board_ctl_regfile_tb.sv
module board_ctl_regfile_tb;

  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              full_diag = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [1:0]        mem_code = 2'd0;
  logic              ev_lost = 1'b0;
  logic              ev_dma_par = 1'b0;
  logic              ev_cpu_bus_par = 1'b0;
  logic              ev_cpu_mem_par = 1'b0;
  logic              ev_mref_mchk = 1'b0;
  logic              cpu_ea_cap = 1'b0;
  logic [14:0]       cpu_ea_in = '0;
  logic              dma_ea_cap = 1'b0;
  logic [14:0]       dma_ea_in = '0;
  logic [3:0]        led_out;
  logic              brk_en;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  board_ctl_regfile #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fd);
    @(negedge clk);
    full_diag = fd;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input int ofs, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(ofs); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int ofs, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(ofs);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input int ofs, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(ofs, d);
    check(req, d, exp);
  endtask

  task automatic t_reset_normal();
    do_reset(1'b0);
    check("R1 led", {28'd0, led_out}, 32'hF);
    check("R1 brk", {31'd0, brk_en}, 32'h1);
    check("R11 rdata after reset", bus_rdata, 32'h0);
    expect_reg("R1 bdiag", 0, 32'h0000C30F);
    expect_reg("R1 memerr", 1, 32'h0);
    expect_reg("R1 cpu ea", 2, 32'h0);
    expect_reg("R1 dma ea", 3, 32'h0);
  endtask

  task automatic t_decode();
    expect_reg("R2 offset 4", 4, 32'h0);
    expect_reg("R2 offset 9", 9, 32'h0);
    expect_reg("R2 offset 15", 15, 32'h0);
  endtask

  task automatic t_bdiag_write();
    bus_write(0, 32'hFFFF_FFF5);
    check("R3 led", {28'd0, led_out}, 32'h5);
    check("R3 brk", {31'd0, brk_en}, 32'h1);
    expect_reg("R3 bdiag readback", 0, 32'h0000C305);
    bus_write(0, 32'h0000_0000);
    expect_reg("R3 bdiag zero write", 0, 32'h0000C300);
  endtask

  task automatic t_memerr_ctl();
    bus_write(1, 32'hFFFF_FFFF);
    expect_reg("R4 ctl all ones", 1, 32'h3);
    bus_write(1, 32'h0000_0001);
    expect_reg("R4 ctl pe only", 1, 32'h1);
  endtask

  task automatic pulse_events(input logic l, input logic dp, input logic cb,
                              input logic cm, input logic mc);
    @(negedge clk);
    ev_lost = l; ev_dma_par = dp; ev_cpu_bus_par = cb; ev_cpu_mem_par = cm; ev_mref_mchk = mc;
    @(negedge clk);
    ev_lost = 0; ev_dma_par = 0; ev_cpu_bus_par = 0; ev_cpu_mem_par = 0; ev_mref_mchk = 0;
  endtask

  task automatic t_sticky();
    pulse_events(1, 1, 0, 0, 0);
    expect_reg("R6 lost+dma set", 1, 32'h19);
    bus_write(1, 32'h09);
    expect_reg("R5 w1c lost", 1, 32'h11);
    bus_write(1, 32'h01);
    expect_reg("R5 zero leaves", 1, 32'h11);
    // clear bit 4 while a DMA parity pulse lands in the same cycle
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 1; bus_wdata = 32'h11; ev_dma_par = 1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; ev_dma_par = 0;
    expect_reg("R6 set beats clear", 1, 32'h11);
    bus_write(1, 32'hF9);
    expect_reg("R5 clear all", 1, 32'h1);
  endtask

  task automatic t_nxm();
    pulse_events(0, 0, 0, 0, 1);
    expect_reg("R7 nxm set", 1, 32'h81);
    bus_write(1, 32'h81);
    pulse_events(0, 0, 1, 0, 0);
    pulse_events(0, 0, 0, 0, 1);
    expect_reg("R7 blocked by cpu bus par", 1, 32'h21);
    bus_write(1, 32'hF9);
    pulse_events(0, 0, 0, 1, 0);
    pulse_events(0, 0, 0, 0, 1);
    expect_reg("R7 blocked by cpu mem par", 1, 32'h41);
    bus_write(1, 32'hF9);
    pulse_events(0, 0, 1, 0, 1);
    expect_reg("R7 same-cycle parity", 1, 32'hA1);
    bus_write(1, 32'hF9);
  endtask

  task automatic t_mcode();
    @(negedge clk);
    mem_code = 2'd2;
    @(negedge clk);
    @(negedge clk);
    expect_reg("R8 mem code", 1, 32'h201);
    mem_code = 2'd0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_eaddr();
    logic [31:0] d;
    @(negedge clk);
    cpu_ea_in = 15'h5A5A; cpu_ea_cap = 1;
    dma_ea_in = 15'h7FFF; dma_ea_cap = 1;
    @(negedge clk);
    cpu_ea_cap = 0; dma_ea_cap = 0;
    cpu_ea_in = 15'h0; dma_ea_in = 15'h0;
    expect_reg("R9 cpu ea", 2, 32'h5A5A);
    expect_reg("R9 dma ea", 3, 32'h7FFF);
    bus_write(2, 32'hFFFF_FFFF);
    bus_write(3, 32'h0);
    expect_reg("R10 cpu ea write ignored", 2, 32'h5A5A);
    expect_reg("R10 dma ea write ignored", 3, 32'h7FFF);
    // R11: rdata holds through idle and write cycles
    bus_read(2, d);
    bus_write(0, 32'h3);
    @(negedge clk);
    check("R11 rdata holds", bus_rdata, 32'h5A5A);
  endtask

  task automatic t_reset_full();
    do_reset(1'b1);
    expect_reg("R1 bdiag full diag", 0, 32'h0000C00F);
    expect_reg("R1 memerr cleared", 1, 32'h0);
    expect_reg("R1 cpu ea cleared", 2, 32'h0);
  endtask

  initial begin
    t_reset_normal();
    t_decode();
    t_bdiag_write();
    t_memerr_ctl();
    t_sticky();
    t_nxm();
    t_mcode();
    t_eaddr();
    t_reset_full();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule